// File: doc/BRIEF.md
# Code-programmed stochastic bit emulator

This block is a digital stand-in for a noise-driven latch that resolves to a random bit with a probability chosen by a 6-bit control code. The top code bit chooses which of two sides of the cell is weakened. The remaining five bits drive that side's binary-weighted cells, either directly or inverted. The difference between the active strengths of the left and right sides shifts a comparison threshold away from its midpoint, and a 16-bit maximal-length LFSR supplies the random value that is compared with it. Over the signed code range, the result is an S-shaped probability curve with 50% at the centre.

Each cycle of use has a reset phase and an evaluate phase. While the enable is low, the cell is equalized and holds no valid bit. On the first clock edge that sees the enable high, the cell draws one random bit and advances the LFSR once. It then keeps that bit, like a one-bit storage cell, for as long as the enable stays high. A read strobe gates the held bit onto a pulse output. A seed port reloads the LFSR so that bit sequences can be reproduced.

Top module: `stoch_bit_emu`

## Requirements
- R1: While reset is asserted, and until the first evaluation after it, bit_q and pulse_o are 0. The reset is asynchronous and active low, and its release passes through a two-flop synchronizer.
- R2: When code[5] is 0, the right-side cells are all off and the left-side cells equal code[4:0], with cell i weighted 2^i. The threshold is 128 + 5*code[4:0], saturated at 255, so codes 26 to 31 give 255.
- R3: When code[5] is 1, the left-side cells are all off and the right-side cells equal ~code[4:0]. The threshold is 128 - 5*(31 - code[4:0]), saturated at 0, so codes 32 to 37 give 0.
- R4: A clock edge that samples en at 1, when the previous edge sampled en at 0, is an evaluation. bit_q becomes 1 exactly when LFSR bits [15:8] are below the threshold of the code sampled at that edge. The LFSR advances once, and it advances at no other edge.
- R5: After an evaluation, bit_q holds its value at every later edge while en stays high, whatever code and rd do.
- R6: A clock edge that samples en at 0 clears bit_q to 0, and pulse_o is 0 during that phase.
- R7: pulse_o equals bit_q while rd is 1 after an evaluation, and pulse_o is 0 whenever rd is 0.
- R8: The LFSR resets to 0x0001 and shifts toward the MSB. Bit 0 takes the XOR of bits 15, 13, 12 and 10.
- R9: An edge with seed_load at 1 loads seed into the LFSR, and a zero seed loads 0x0001. If that edge is also an evaluation, the bit is drawn from the state before the load, and the load takes the place of the advance.
- R10: Codes 000000 and 111111 both give a threshold of 128, which is a 50% probability. From the same seed, the count of 1s over 4096 evaluations does not decrease as the code steps through the signed order 32..63, 0..31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Low: equalize (reset phase). High: evaluate, then hold |
| rd | input | 1 | Read strobe gating the pulse output |
| code | input | 6 | Probability control code |
| seed_load | input | 1 | Load seed into the LFSR at this edge |
| seed | input | 16 | LFSR seed value |
| bit_q | output | 1 | Held random bit |
| pulse_o | output | 1 | Read pulse (held bit while rd is 1) |

## Verification
A seed load and an evaluation can fall on the same clock edge. The bench provokes this by raising en and seed_load together. It then checks two things: that the drawn bit matches the LFSR state before the load, and that the next evaluation draws from the new seed rather than from an advanced state. A reference model of the LFSR and the threshold, built from the requirements, predicts every drawn bit, and a hold interval proves that no extra advance occurs while the bit is held.

// File: rtl/sbe_pkg.sv
package sbe_pkg;
  localparam int DEF_CODE_W = 6;
  localparam int DEF_LFSR_W = 16;
  localparam int DEF_TH_W   = 8;
  localparam int DEF_STEP   = 5;
  localparam logic [15:0] DEF_TAPS = 16'hB400;
  localparam logic [15:0] DEF_SEED = 16'h0001;

  typedef enum logic {
    PH_EQUAL = 1'b0,
    PH_HELD  = 1'b1
  } phase_t;
endpackage

// File: rtl/sbe_side_decode.sv
module sbe_side_decode #(
  parameter int CODE_W = 6,
  localparam int CELLS = CODE_W - 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [CELLS-1:0]  left_on,
  output logic [CELLS-1:0]  right_on
);
  logic side_sel;
  assign side_sel = code[CODE_W-1];

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign left_on[i]  = ~side_sel &  code[i];
    assign right_on[i] =  side_sel & ~code[i];
  end
endmodule

// File: rtl/sbe_threshold.sv
module sbe_threshold #(
  parameter int CELLS = 5,
  parameter int TH_W  = 8,
  parameter int STEP  = 5,
  localparam int SW    = TH_W + CELLS + 6,
  localparam int MID   = 1 << (TH_W - 1),
  localparam int MAXTH = (1 << TH_W) - 1
) (
  input  logic [CELLS-1:0] left_on,
  input  logic [CELLS-1:0] right_on,
  output logic [TH_W-1:0]  thr
);
  logic signed [SW-1:0] acc;

  always_comb begin
    acc = $signed(SW'(MID)) + $signed(SW'(STEP)) *
          ($signed(SW'(left_on)) - $signed(SW'(right_on)));
    if (acc < $signed(SW'(0)))
      thr = '0;
    else if (acc > $signed(SW'(MAXTH)))
      thr = TH_W'(MAXTH);
    else
      thr = acc[TH_W-1:0];
  end
endmodule

// File: rtl/sbe_lfsr.sv
module sbe_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] INIT = 16'h0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         fb;

  always_comb begin
    fb = ^(q & TAPS);
    if (load)
      q_n = (seed == '0) ? INIT : seed;
    else if (step)
      q_n = {q[W-2:0], fb};
    else
      q_n = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= INIT;
    else if (load || step)
      q <= q_n;
  end
endmodule

// File: rtl/stoch_bit_emu.sv
module stoch_bit_emu
  import sbe_pkg::*;
#(
  parameter int               CODE_W = DEF_CODE_W,
  parameter int               LFSR_W = DEF_LFSR_W,
  parameter int               TH_W   = DEF_TH_W,
  parameter int               STEP   = DEF_STEP,
  parameter logic [LFSR_W-1:0] TAPS  = DEF_TAPS,
  parameter logic [LFSR_W-1:0] INIT  = DEF_SEED,
  localparam int CELLS = CODE_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rd,
  input  logic [CODE_W-1:0] code,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  output logic              bit_q,
  output logic              pulse_o
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= 2'b00;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [CELLS-1:0]  left_on, right_on;
  logic [TH_W-1:0]   thr;
  logic [LFSR_W-1:0] lfsr_q;

  sbe_side_decode #(.CODE_W(CODE_W)) u_dec (
    .code     (code),
    .left_on  (left_on),
    .right_on (right_on)
  );

  sbe_threshold #(.CELLS(CELLS), .TH_W(TH_W), .STEP(STEP)) u_thr (
    .left_on  (left_on),
    .right_on (right_on),
    .thr      (thr)
  );

  logic en_q, en_n;
  logic eval;
  logic bit_n;
  phase_t phase_q, phase_n;
  logic draw;

  assign eval = en & ~en_q;
  assign draw = (lfsr_q[LFSR_W-1 -: TH_W] < thr);

  sbe_lfsr #(.W(LFSR_W), .TAPS(TAPS), .INIT(INIT)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (eval),
    .load  (seed_load),
    .seed  (seed),
    .q     (lfsr_q)
  );

  always_comb begin
    en_n    = en;
    bit_n   = bit_q;
    phase_n = phase_q;
    if (!en) begin
      bit_n   = 1'b0;
      phase_n = PH_EQUAL;
    end else if (eval) begin
      bit_n   = draw;
      phase_n = PH_HELD;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      bit_q   <= 1'b0;
      phase_q <= PH_EQUAL;
    end else begin
      en_q    <= en_n;
      bit_q   <= bit_n;
      phase_q <= phase_n;
    end
  end

  logic valid_q;
  assign valid_q = (phase_q == PH_HELD);
  assign pulse_o = valid_q & rd & bit_q;
endmodule

// File: rtl/sbe_chk.sv
module sbe_chk #(
  parameter int CODE_W = 6,
  parameter int LFSR_W = 16,
  parameter int TH_W   = 8,
  localparam int CELLS = CODE_W - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              en_q,
  input logic              rd,
  input logic              seed_load,
  input logic [CODE_W-1:0] code,
  input logic              bit_q,
  input logic              pulse_o,
  input logic              valid_q,
  input logic [LFSR_W-1:0] lfsr_q,
  input logic [CELLS-1:0]  left_on,
  input logic [CELLS-1:0]  right_on,
  input logic [TH_W-1:0]   thr
);
  // R5
  hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && en) |=> $stable(bit_q));

  // R6
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bit_q && !pulse_o));

  // R7
  pulse_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> !pulse_o);

  // R4
  lfsr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_load && !(en && !en_q)) |=> $stable(lfsr_q));

  // R4
  zero_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !en_q && thr == '0) |=> !bit_q);

  // R2
  side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((|left_on) && (|right_on)));

  // R10
  mid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0 || code == '1) |-> (thr == TH_W'(1 << (TH_W - 1))));
endmodule

bind stoch_bit_emu sbe_chk #(.CODE_W(CODE_W), .LFSR_W(LFSR_W), .TH_W(TH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .en        (en),
  .en_q      (en_q),
  .rd        (rd),
  .seed_load (seed_load),
  .code      (code),
  .bit_q     (bit_q),
  .pulse_o   (pulse_o),
  .valid_q   (valid_q),
  .lfsr_q    (lfsr_q),
  .left_on   (left_on),
  .right_on  (right_on),
  .thr       (thr)
);

// File: tb/sim_stoch_bit_emu.sv
`timescale 1ns/1ps
module sim_stoch_bit_emu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en, rd, seed_load;
  logic [5:0]  code;
  logic [15:0] seed;
  logic        bit_q, pulse_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [15:0] m;   // reference LFSR state

  always #5 clk = ~clk;

  stoch_bit_emu u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .rd(rd), .code(code),
    .seed_load(seed_load), .seed(seed), .bit_q(bit_q), .pulse_o(pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int thr_of(input logic [5:0] c);
    int s;
    if (!c[5]) s = 128 + 5 * int'(c[4:0]);
    else       s = 128 - 5 * (31 - int'(c[4:0]));
    if (s < 0)   s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic mdl_draw(input logic [5:0] c);
    logic b;
    b = (int'(m[15:8]) < thr_of(c));
    m = nxt(m);
    return b;
  endfunction

  // one evaluation, then one equalize edge; returns the drawn bit
  task automatic eval_once(input logic [5:0] c, input logic ld,
                           input logic [15:0] sd, output logic got);
    @(negedge clk);
    code = c; en = 1'b1; seed_load = ld; seed = sd;
    @(negedge clk);
    got = bit_q;
    en = 1'b0; seed_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic load_seed(input logic [15:0] sd);
    @(negedge clk);
    seed_load = 1'b1; seed = sd;
    @(negedge clk);
    seed_load = 1'b0;
    m = (sd == 16'h0) ? 16'h0001 : sd;
  endtask

  task automatic t_reset;
    en = 0; rd = 1; seed_load = 0; code = 6'd0; seed = 16'h0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bit_q == 1'b0, "R1 bit_q in reset", bit_q, 0);
    check(pulse_o == 1'b0, "R1 pulse_o in reset", pulse_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(bit_q == 1'b0, "R1 bit_q after release", bit_q, 0);
    m = 16'h0001;
  endtask

  // exact draws against the model across several codes (R2 R3 R4 R8)
  task automatic t_exact;
    logic got, exp;
    logic [5:0] codes [8] = '{6'd0, 6'd13, 6'd27, 6'd31, 6'd32, 6'd37, 6'd45, 6'd63};
    int bad = 0;
    int first_bad_act = 0, first_bad_exp = 0;
    // from reset state 0x0001 (R8): first draw top byte 0 < 128
    eval_once(6'd0, 1'b0, 16'h0, got);
    exp = mdl_draw(6'd0);
    check(got == exp, "R8 first draw after reset", got, exp);
    load_seed(16'h5A3C);
    for (int k = 0; k < 256; k++) begin
      logic [5:0] c;
      c = codes[k % 8];
      eval_once(c, 1'b0, 16'h0, got);
      exp = mdl_draw(c);
      if (got !== exp) begin
        if (bad == 0) begin first_bad_act = got; first_bad_exp = exp; end
        bad++;
      end
    end
    check(bad == 0, "R2 R3 R4 exact draw sequence", first_bad_act, first_bad_exp);
  endtask

  // hold while en stays high, then clear when it drops (R5 R6 R7 R4)
  task automatic t_hold;
    logic b, exp, got;
    int bad = 0;
    load_seed(16'h00C3);
    @(negedge clk);
    code = 6'd31; en = 1'b1; rd = 1'b1;
    exp = mdl_draw(6'd31);
    @(negedge clk);
    b = bit_q;
    check(b == exp, "R4 held draw", b, exp);
    check(pulse_o == b, "R7 pulse follows bit with rd high", pulse_o, b);
    for (int k = 0; k < 6; k++) begin
      code = (k % 2 == 0) ? 6'd32 : 6'd0;
      rd = k[0];
      @(negedge clk);
      if (bit_q !== b) bad++;
      if (pulse_o !== (b & rd)) bad++;
    end
    check(bad == 0, "R5 R7 bit held while en high", bad, 0);
    rd = 1'b0;
    @(negedge clk);
    check(pulse_o == 1'b0, "R7 pulse low with rd low", pulse_o, 0);
    en = 1'b0; rd = 1'b1;
    @(negedge clk);
    check(bit_q == 1'b0, "R6 bit cleared on equalize", bit_q, 0);
    check(pulse_o == 1'b0, "R6 pulse low on equalize", pulse_o, 0);
    // only one advance during the whole hold
    eval_once(6'd16, 1'b0, 16'h0, got);
    exp = mdl_draw(6'd16);
    check(got == exp, "R4 single advance across hold", got, exp);
  endtask

  // seed load on the same edge as an evaluation (R9)
  task automatic t_collide;
    logic got, exp;
    load_seed(16'h8F21);
    eval_once(6'd8, 1'b1, 16'h1234, got);
    exp = mdl_draw(6'd8);
    m = 16'h1234;
    check(got == exp, "R9 collide draw uses old state", got, exp);
    for (int k = 0; k < 16; k++) begin
      eval_once(6'd0, 1'b0, 16'h0, got);
      exp = mdl_draw(6'd0);
      check(got == exp, "R9 draws continue from loaded seed", got, exp);
    end
    load_seed(16'h0000);
    eval_once(6'd0, 1'b0, 16'h0, got);
    exp = mdl_draw(6'd0);
    check(got == exp, "R9 zero seed loads 0x0001", got, exp);
  endtask

  // rate sweep in signed code order (R10 R2 R3)
  task automatic t_sweep;
    logic [5:0] order [10] = '{6'd32, 6'd38, 6'd44, 6'd52, 6'd63,
                               6'd0, 6'd8, 6'd16, 6'd24, 6'd31};
    int prev = -1;
    for (int i = 0; i < 10; i++) begin
      int ones = 0, mones = 0;
      logic got;
      load_seed(16'hACE1);
      for (int k = 0; k < 4096; k++) begin
        eval_once(order[i], 1'b0, 16'h0, got);
        if (got) ones++;
        if (mdl_draw(order[i])) mones++;
      end
      check(ones == mones, "R10 rate matches threshold model", ones, mones);
      check(ones >= prev, "R10 rate monotone in signed order", ones, prev);
      if (order[i] == 6'd32)
        check(ones == 0, "R3 saturated low threshold", ones, 0);
      if (order[i] == 6'd0 || order[i] == 6'd63)
        check(ones > 1900 && ones < 2200, "R10 mid code near 50%", ones, 2048);
      if (order[i] == 6'd31)
        check(ones > 4050, "R2 saturated high threshold", ones, 4080);
      prev = ones;
    end
  endtask

  initial begin
    t_reset();
    t_exact();
    t_hold();
    t_collide();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule